// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight asynchronous input lines and turns each into a level-sensitive interrupt source. Each line passes through a two-flop synchroniser and then a debounce filter of its own. The filter counts ticks of a shared millisecond prescaler, and a new level is accepted only after the line has held it for the whole programmed window. The lines are inputs only. Nothing in the block drives them.

Software reaches the block through a small register port. Writes are single-cycle strobes and reads are combinational. For each channel, software sets a polarity, an interrupt enable, a data-enable mask, a debounce window and a one-shot arm bit.

- A channel captures an event when its debounced level equals its polarity while it is armed. The capture consumes the arm bit.
- The capture sets a sticky raw status bit, which stays set until software clears it.
- Masked status is raw status gated by the enable. The single interrupt output is the OR of the masked status bits.

Top module: `debounce_irq_bank`

## Requirements
- R1: The eight lines are input-only. Writes to the data (0x00), raw status (0x1C) and masked status (0x20) offsets change no state.
- R2: Channel i has a window word at offset 0x40 + 4*i. Only its low 12 bits are stored and read back, and a stored value of 0 filters like 1.
- R3: A line change is accepted only after it stays stable for the window count of prescaler ticks. A pulse no longer than (window-1) tick periods leaves the debounced level unchanged.
- R4: Offset 0x00 reads the debounced levels ANDed with the data-enable mask at 0x04, so channels with a clear mask bit read 0.
- R5: The polarity word at 0x14 selects the active level per channel: 1 means active high and 0 means active low. An armed channel captures when its debounced level equals its polarity bit.
- R6: The arm word at 0x28 is required for a capture. Each armed bit clears itself when its channel captures, and a held active level raises nothing more until the channel is re-armed.
- R7: Raw status at 0x1C stays set after the input returns to idle. Writing 1 to a bit of 0x24 clears that bit, and 0 bits in the same write leave their channels alone.
- R8: Masked status at 0x20 equals raw status ANDed with the enable at 0x18, and irq_o is high exactly when any masked bit is set.
- R9: After reset, every word reads 0 except the window words, which read 1, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_LINES | Asynchronous external lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | WDATA_W | Write data |
| reg_rdata_o | output | RDATA_W | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
A register write lands on the clock edge of its strobe and reads back in the next cycle. A capture that depends on a just-written arm bit shows in raw status one cycle later, so the checks wait two cycles after such a write. A pin edge reaches the debounced level after two synchroniser cycles plus between (window-1)*TICK_DIV+1 and window*TICK_DIV cycles, depending on the tick phase. The bench therefore holds accepted pulses for window*TICK_DIV+6 cycles and keeps rejected pulses at or below (window-1)*TICK_DIV cycles, which makes each outcome independent of the prescaler phase.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_DEN  = 8'h04;
  localparam logic [7:0] OFF_POL  = 8'h14;
  localparam logic [7:0] OFF_IEN  = 8'h18;
  localparam logic [7:0] OFF_RAW  = 8'h1C;
  localparam logic [7:0] OFF_MSK  = 8'h20;
  localparam logic [7:0] OFF_CLR  = 8'h24;
  localparam logic [7:0] OFF_ARM  = 8'h28;
  localparam logic [7:0] OFF_WIN  = 8'h40;
  localparam int unsigned WIN_STRIDE = 4;
endpackage

// File: rtl/dbirq_tick.sv
module dbirq_tick #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dbirq_line.sv
module dbirq_line #(
  parameter int unsigned WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             level_o
);
  logic [1:0]       sync_q;
  logic             lvl_q;
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W:0]   cnt_inc;
  logic [WIN_W:0]   limit;

  // window 0 behaves as 1
  assign limit   = (win_i == '0) ? (WIN_W+1)'(1) : {1'b0, win_i};
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_inc >= limit) begin
          lvl_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_inc[WIN_W-1:0];
        end
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/debounce_irq_bank.sv
module debounce_irq_bank
  import dbirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned WIN_W     = 12,
  parameter int unsigned TICK_DIV  = 125000,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned WDATA_W   = 12,
  parameter int unsigned RDATA_W   = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [WDATA_W-1:0]   reg_wdata_i,
  output logic [RDATA_W-1:0]   reg_rdata_o,
  output logic                 irq_o
);
  localparam int unsigned N = NUM_LINES;

  logic         tick;
  logic [N-1:0] lvl, den_q, pol_q, ie_q, arm_q, raw_q;
  logic [N-1:0] cap, wmask, win_sel;
  logic [WIN_W-1:0] win_q [N];
  logic we_den, we_pol, we_ie, we_arm, we_clr;

  assign wmask  = reg_wdata_i[N-1:0];
  assign we_den = reg_we_i && (reg_addr_i == ADDR_W'(OFF_DEN));
  assign we_pol = reg_we_i && (reg_addr_i == ADDR_W'(OFF_POL));
  assign we_ie  = reg_we_i && (reg_addr_i == ADDR_W'(OFF_IEN));
  assign we_arm = reg_we_i && (reg_addr_i == ADDR_W'(OFF_ARM));
  assign we_clr = reg_we_i && (reg_addr_i == ADDR_W'(OFF_CLR));

  dbirq_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign win_sel[i] = (reg_addr_i == ADDR_W'(OFF_WIN + WIN_STRIDE*i));

    dbirq_line #(.WIN_W(WIN_W)) i_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .pin_i   (pins_i[i]),
      .win_i   (win_q[i]),
      .level_o (lvl[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      win_q[i] <= WIN_W'(1);
      else if (reg_we_i && win_sel[i])  win_q[i] <= reg_wdata_i[WIN_W-1:0];
    end
  end

  // armed channel whose stable level equals its polarity
  assign cap = ~(lvl ^ pol_q) & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      den_q <= '0;
      pol_q <= '0;
      ie_q  <= '0;
      arm_q <= '0;
      raw_q <= '0;
    end else begin
      if (we_den) den_q <= wmask;
      if (we_pol) pol_q <= wmask;
      if (we_ie)  ie_q  <= wmask;
      arm_q <= we_arm ? wmask : (arm_q & ~cap);
      raw_q <= (raw_q & ~(we_clr ? wmask : '0)) | cap;
    end
  end

  assign irq_o = |(raw_q & ie_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_W'(OFF_DATA): reg_rdata_o[N-1:0] = lvl & den_q;
      ADDR_W'(OFF_DEN):  reg_rdata_o[N-1:0] = den_q;
      ADDR_W'(OFF_POL):  reg_rdata_o[N-1:0] = pol_q;
      ADDR_W'(OFF_IEN):  reg_rdata_o[N-1:0] = ie_q;
      ADDR_W'(OFF_RAW):  reg_rdata_o[N-1:0] = raw_q;
      ADDR_W'(OFF_MSK):  reg_rdata_o[N-1:0] = raw_q & ie_q;
      ADDR_W'(OFF_ARM):  reg_rdata_o[N-1:0] = arm_q;
      default: begin
        for (int k = 0; k < N; k++) begin
          if (win_sel[k]) reg_rdata_o[WIN_W-1:0] = win_q[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/dbirq_checker.sv
module dbirq_checker #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick,
  input logic [N-1:0] lvl,
  input logic [N-1:0] raw_q,
  input logic [N-1:0] arm_q,
  input logic         we_clr,
  input logic         we_arm,
  input logic         irq_o
);
  AST_LEVEL_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(lvl)); // R3

  AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_clr |=> (($past(raw_q) & ~raw_q) == '0)); // R7

  AST_NEW_RAW_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(arm_q)) == '0)); // R6

  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_arm |=> ((raw_q & ~$past(raw_q) & arm_q) == '0)); // R6

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_q != '0)); // R8
endmodule

bind debounce_irq_bank dbirq_checker #(.N(NUM_LINES)) i_dbirq_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .lvl    (lvl),
  .raw_q  (raw_q),
  .arm_q  (arm_q),
  .we_clr (we_clr),
  .we_arm (we_arm),
  .irq_o  (irq_o)
);

// File: tb/test_debounce_irq_bank.sv
module test_debounce_irq_bank;
  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  debounce_irq_bank #(.TICK_DIV(DIV)) i_debounce_irq_bank (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [11:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] bit_of(int ch);
    return 8'(1) << ch;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R9 reset state
    rd(8'h00, v); chk("R9 data", v, 0);
    rd(8'h1C, v); chk("R9 raw", v, 0);
    rd(8'h28, v); chk("R9 arm", v, 0);
    rd(8'h40, v); chk("R9 win0", v, 1);
    rd(8'h5C, v); chk("R9 win7", v, 1);
    chk("R9 irq", {31'd0, irq}, 0);

    // R2 window storage
    wr(8'h4C, 12'hFFF); rd(8'h4C, v); chk("R2 win3 12 bit", v, 32'hFFF);
    wr(8'h4C, 12'd1);   rd(8'h4C, v); chk("R2 win3 restore", v, 1);

    // R4 data with mask, R1 writes ignored
    wr(8'h04, 12'hFF);
    pins = 8'hA5; cyc(2*DIV + 8);
    rd(8'h00, v); chk("R4 data full mask", v, 32'hA5);
    wr(8'h04, 12'h0F);
    rd(8'h00, v); chk("R4 data part mask", v, 32'h05);
    wr(8'h00, 12'hFF); rd(8'h00, v); chk("R1 data write ignored", v, 32'h05);
    wr(8'h1C, 12'hFF); rd(8'h1C, v); chk("R1 raw write ignored", v, 0);
    wr(8'h20, 12'hFF); rd(8'h20, v); chk("R1 masked write ignored", v, 0);

    // R2 window 0 acts as 1
    wr(8'h48, 12'd0);
    pins = 8'h00; cyc(2*DIV + 8);
    wr(8'h04, 12'hFF);
    rd(8'h00, v); chk("R2 win0 filters as 1", v, 0);
    wr(8'h48, 12'd1);

    // R5/R6/R7/R8 directed
    wr(8'h14, 12'hFF); wr(8'h18, 12'h01); wr(8'h24, 12'hFF); wr(8'h28, 12'h01);
    pins[0] = 1'b1; cyc(2*DIV + 8);
    rd(8'h1C, v); chk("R5 high capture", v, 32'h01);
    rd(8'h28, v); chk("R6 arm consumed", v, 0);
    chk("R8 irq set", {31'd0, irq}, 1);
    pins[0] = 1'b0; cyc(2*DIV + 8);
    rd(8'h1C, v); chk("R7 sticky after idle", v, 32'h01);
    wr(8'h24, 12'h00); rd(8'h1C, v); chk("R7 zero clear ignored", v, 32'h01);
    wr(8'h24, 12'h01); rd(8'h1C, v); chk("R7 clear", v, 0);
    chk("R8 irq cleared", {31'd0, irq}, 0);
    pins[0] = 1'b1; cyc(2*DIV + 8);
    rd(8'h1C, v); chk("R6 no capture unarmed", v, 0);
    wr(8'h28, 12'h01); cyc(2);
    rd(8'h1C, v); chk("R6 rearm captures held level", v, 32'h01);
    wr(8'h14, 12'h00); wr(8'h24, 12'hFF); wr(8'h28, 12'h02); cyc(2);
    rd(8'h1C, v); chk("R5 low capture", v, 32'h02);
    rd(8'h20, v); chk("R8 masked gated", v, 0);
    chk("R8 irq masked off", {31'd0, irq}, 0);

    // random single-channel events
    for (int it = 0; it < 40; it++) begin
      int ch = int'($urandom % 8);
      logic pol = 1'($urandom % 2);
      int win = 1 + int'($urandom % 4);
      logic ie = 1'($urandom % 2);
      logic lng = (win == 1) ? 1'b1 : 1'($urandom % 2);
      int len;
      logic [7:0] e_raw;
      wr(8'h14, pol ? 12'hFF : 12'h00);
      wr(8'h40 + 8'(4*ch), 12'(win));
      wr(8'h18, ie ? 12'(bit_of(ch)) : 12'h0);
      pins[ch] = ~pol;
      cyc((win + 1)*DIV + 8);
      wr(8'h24, 12'hFF);
      wr(8'h28, 12'(bit_of(ch)));
      len = lng ? win*DIV + 6 : 1 + int'($urandom % ((win - 1)*DIV));
      pins[ch] = pol;
      cyc(len);
      pins[ch] = ~pol;
      cyc(4);
      e_raw = lng ? bit_of(ch) : 8'h00;
      rd(8'h1C, v); chk(lng ? "R3 R5 long pulse raw" : "R3 short pulse rejected", v, {24'd0, e_raw});
      rd(8'h28, v); chk("R6 arm after pulse", v, lng ? 32'h0 : {24'd0, bit_of(ch)});
      rd(8'h20, v); chk("R8 masked", v, {24'd0, e_raw & (ie ? bit_of(ch) : 8'h0)});
      chk("R8 irq", {31'd0, irq}, {31'd0, lng & ie});
    end
    report();
  end
endmodule